// File: doc/BRIEF.md
# Length-Prefixed Serial Configuration Loader

This block takes configuration bytes from an asynchronous serial line (8 data bits, one start bit, one stop bit, no parity) and loads them into a bank of nineteen byte-wide control registers. The receiver is built from a 16x oversampling tick counter and samples each bit at its middle. The clock cycles per sixteenth of a bit are set by a parameter. For example, 651 at 200 MHz gives 19200 baud.

A configuration string opens with a count byte that says how many register bytes follow. Those bytes fill register positions 2, 3, 4 and so on, in order. Positions past the count keep whatever they held before. The whole string is staged and written into the bank only after its final byte, so a partly received string never reaches the outputs.

The bank is decoded into named fields: a tuning word, two packet lengths, a spectral inversion flag, a threshold gain, offset and limits, two accumulator lengths, a signal/noise view selector, a unique-word qualifier and a noise holdoff count. Several of these fields are stored in complemented form and are presented at the outputs as plain counts.

Top module: `ser_cfg_loader`

## Requirements
- R1: A byte is received least significant bit first. There is one start bit, eight data bits and one stop bit, each lasting 16*TICK_DIV clock cycles, and every bit is sampled once at its middle.
- R2: A low pulse on `rxd` that is back high at the middle of the start bit is ignored. It produces no byte and does not set `frame_err`.
- R3: A byte whose stop bit is sampled low is discarded and sets `frame_err`. It also abandons any string in progress, so the next good byte is read as a count. `frame_err` clears on the next good byte.
- R4: The first byte of a string is a count n. When n is 0 or greater than 19, that byte is dropped and the byte after it is read as a new count.
- R5: With a count n, the following n bytes go to register positions 2 through n+1. All higher positions keep their previous values.
- R6: No output field changes while a string is still arriving. All bytes of a string take effect together, once its last byte has been received.
- R7: Reset (synchronous, `rst_n` low) restores these output values: `tune_word` 0x1F4, both packet lengths 512, `spec_inv` 0, `thr_gain` 0, `thr_lo` 0x80, `thr_hi` 0xF0, both accumulator lengths 192, `thr_offset` 0, `view_sig` 5, `view_noise` 1, `uw_qual` 12, `holdoff_sym` 0. These come from the stored bytes F4 01 00 FE 00 00 80 00 F0 00 40 40 00 51 00 FE 0C FF FF at positions 2 through 20.
- R8: `tune_word` is the low 12 bits of the 16-bit value formed from position 2 (low byte) and position 3 (high byte).
- R9: `pkt_len_a` is 0x10000 minus the 16-bit value at positions 4 and 5, low byte first. `pkt_len_b` is computed the same way from positions 16 and 17. The result is 17 bits wide, so a stored 0 reads as 65536.
- R10: `sig_acc_len` is 256 minus the byte at position 12. `noise_acc_len` is 256 minus the byte at position 13.
- R11: `holdoff_sym` is 0xFFFF minus the 16-bit value at positions 19 and 20, low byte first.
- R12: These fields map directly to stored bytes:
  - `spec_inv` is bit 0 of position 6.
  - `thr_gain` is position 7.
  - `thr_lo` is positions 8 and 9, low byte first.
  - `thr_hi` is positions 10 and 11, low byte first.
  - `thr_offset` is position 14.
  - `view_sig` is the upper nibble of position 15 and `view_noise` is its lower nibble.
  - `uw_qual` is the low 4 bits of position 18.
- R13: A count of 19 rewrites every position from 2 through 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| frame_err | output | 1 | Last received byte had a low stop bit |
| tune_word | output | 12 | Tuning steps above the base frequency |
| spec_inv | output | 1 | Spectral inversion enable |
| thr_gain | output | 8 | Threshold gain |
| thr_lo | output | 16 | Threshold lower limit |
| thr_hi | output | 16 | Threshold upper limit |
| pkt_len_a | output | 17 | Packet length A in symbols |
| pkt_len_b | output | 17 | Packet length B in symbols |
| sig_acc_len | output | 9 | Signal accumulator length in symbols |
| noise_acc_len | output | 9 | Noise accumulator length in symbols |
| thr_offset | output | 8 | Threshold offset |
| view_sig | output | 4 | Signal view selector |
| view_noise | output | 4 | Noise view selector |
| uw_qual | output | 4 | Unique-word zero-count qualifier |
| holdoff_sym | output | 16 | Noise measurement holdoff in symbols |

## Verification
The assertions rely on the serial line obeying the receiver's timing:
- Every bit is held steady for close to 16*TICK_DIV cycles.
- Received bytes are therefore at least one bit time apart. This is what makes a one-cycle byte strobe and a stage-then-commit order hold.

The stimulus drives every bit for exactly that many cycles and leaves at least two idle bit times between bytes. After a byte with a low stop bit, it returns the line high before the next start bit. The start-bit glitch is kept to a quarter of a bit so that it is plainly shorter than the half-bit check.

// File: rtl/scl_pkg.sv
// Package: shared constants, types and field positions for the serial
// configuration loader. Index 0 of the bank is string position 2.
package scl_pkg;
    localparam int CFG_REGS = 19;

    typedef logic [CFG_REGS-1:0][7:0] cfg_bank_t;

    // Reset contents, index 18 first down to index 0
    localparam cfg_bank_t CFG_DEFAULT = {
        8'hFF, 8'hFF, 8'h0C, 8'hFE, 8'h00, 8'h51, 8'h00, 8'h40, 8'h40, 8'h00,
        8'hF0, 8'h00, 8'h80, 8'h00, 8'h00, 8'hFE, 8'h00, 8'h01, 8'hF4
    };

    // Field positions within the bank (string position minus 2)
    localparam int P_TUNE    = 0;
    localparam int P_LEN_A   = 2;
    localparam int P_SPEC    = 4;
    localparam int P_GAIN    = 5;
    localparam int P_THR_LO  = 6;
    localparam int P_THR_HI  = 8;
    localparam int P_SIG_ACC = 10;
    localparam int P_NOI_ACC = 11;
    localparam int P_OFFSET  = 12;
    localparam int P_VIEW    = 13;
    localparam int P_LEN_B   = 14;
    localparam int P_UWQ     = 16;
    localparam int P_HOLD    = 17;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
    typedef enum logic [1:0] {AS_COUNT, AS_COLLECT, AS_COMMIT} asm_state_t;
endpackage

// File: rtl/scl_uart_rx.sv
// Module: scl_uart_rx
// Receives 8N1 bytes with a 16x oversampling tick and samples each bit at
// its middle. Assumes TICK_DIV >= 2 and SYNC_STAGES >= 2, and that rxd idles
// high. A start is taken only on a high-to-low edge, so a line left low after
// a bad stop bit is not mistaken for a new start.
module scl_uart_rx
    import scl_pkg::*;
#(
    parameter int TICK_DIV    = 651,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       ferr_pulse,
    output logic       frame_err
);
    localparam int PW = $clog2(TICK_DIV + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s, rx_prev, fall, tick;
    logic [PW-1:0]          pre;
    logic [3:0]             tcnt;
    logic [2:0]             bitn;
    logic [7:0]             sh;
    rx_state_t              state;

    assign rx_s = sync_q[SYNC_STAGES-1];
    assign fall = rx_prev & ~rx_s;
    assign tick = (pre == PW'(TICK_DIV - 1));

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '1;
            rx_prev <= 1'b1;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], rxd};
            rx_prev <= rx_s;
        end
    end

    // Prescaler: one tick per sixteenth of a bit, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n || state == RX_IDLE || tick) pre <= '0;
        else                                    pre <= pre + 1'b1;
    end

    // Bit framing: start check at half a bit, then data and stop every 16 ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            tcnt       <= '0;
            bitn       <= '0;
            sh         <= '0;
            byte_vld   <= 1'b0;
            byte_data  <= '0;
            ferr_pulse <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            byte_vld   <= 1'b0;
            ferr_pulse <= 1'b0;
            case (state)
                RX_IDLE: begin
                    tcnt <= '0;
                    if (fall) state <= RX_START;
                end
                RX_START: if (tick) begin
                    if (tcnt == 4'd7) begin
                        tcnt  <= '0;
                        bitn  <= '0;
                        state <= rx_s ? RX_IDLE : RX_DATA;
                    end else tcnt <= tcnt + 1'b1;
                end
                RX_DATA: if (tick) begin
                    if (tcnt == 4'd15) begin
                        tcnt <= '0;
                        sh   <= {rx_s, sh[7:1]};
                        if (bitn == 3'd7) state <= RX_STOP;
                        else              bitn  <= bitn + 1'b1;
                    end else tcnt <= tcnt + 1'b1;
                end
                RX_STOP: if (tick) begin
                    if (tcnt == 4'd15) begin
                        state <= RX_IDLE;
                        if (rx_s) begin
                            byte_vld  <= 1'b1;
                            byte_data <= sh;
                            frame_err <= 1'b0;
                        end else begin
                            ferr_pulse <= 1'b1;
                            frame_err  <= 1'b1;
                        end
                    end else tcnt <= tcnt + 1'b1;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R3
    vld_ferr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && ferr_pulse));
    // R1
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
    // R3
    ferr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_pulse |-> frame_err);
endmodule

// File: rtl/scl_assembler.sv
// Module: scl_assembler
// Interprets the byte stream as count-prefixed strings. Register bytes are
// collected into a staging bank, and a one-cycle commit is raised after the
// last one. Assumes bytes arrive at least one cycle apart.
module scl_assembler
    import scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       ferr_pulse,
    output logic       commit,
    output logic [7:0] commit_cnt,
    output cfg_bank_t  stage
);
    localparam int IW = $clog2(CFG_REGS);

    asm_state_t    state;
    logic [7:0]    cnt;
    logic [IW-1:0] idx;
    logic          cnt_ok;

    assign cnt_ok     = (byte_data != 8'd0) && (byte_data <= 8'(CFG_REGS));
    assign commit     = (state == AS_COMMIT);
    assign commit_cnt = cnt;

    // String sequencing: count, collect, commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= AS_COUNT;
            cnt   <= '0;
            idx   <= '0;
            stage <= '0;
        end else begin
            case (state)
                AS_COUNT: if (byte_vld && cnt_ok) begin
                    cnt   <= byte_data;
                    idx   <= '0;
                    state <= AS_COLLECT;
                end
                AS_COLLECT: begin
                    if (ferr_pulse) state <= AS_COUNT;
                    else if (byte_vld) begin
                        stage[idx] <= byte_data;
                        if (8'(idx) == cnt - 8'd1) state <= AS_COMMIT;
                        else                       idx   <= idx + 1'b1;
                    end
                end
                AS_COMMIT: state <= AS_COUNT;
                default:   state <= AS_COUNT;
            endcase
        end
    end

    // R4
    commit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_cnt != 8'd0 && commit_cnt <= 8'(CFG_REGS)));
    // R6
    commit_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(byte_vld));
    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AS_COLLECT) |-> (8'(idx) < cnt));
endmodule

// File: rtl/scl_reg_bank.sv
// Module: scl_reg_bank
// Holds the configuration bytes. On commit, positions below the count take the
// staged bytes and the rest are kept. Reset loads the factory defaults.
module scl_reg_bank
    import scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic [7:0] commit_cnt,
    input  cfg_bank_t  stage,
    output cfg_bank_t  regs
);
    for (genvar i = 0; i < CFG_REGS; i++) begin : g_reg
        // One register byte: default on reset, staged byte when covered by a commit
        always_ff @(posedge clk) begin
            if (!rst_n)                              regs[i] <= CFG_DEFAULT[i];
            else if (commit && (8'(i) < commit_cnt)) regs[i] <= stage[i];
        end
    end

    // R5
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (regs[0] == $past(stage[0])));
    // R5
    tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_cnt < 8'(CFG_REGS)) |=>
            (regs[CFG_REGS-1] == $past(regs[CFG_REGS-1])));
    // R6
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs));
endmodule

// File: rtl/ser_cfg_loader.sv
// Module: ser_cfg_loader (top)
// Serial receiver, string assembler and register bank, with the bank decoded
// into named fields. Complemented fields are presented as plain counts.
module ser_cfg_loader
    import scl_pkg::*;
#(
    parameter int TICK_DIV    = 651,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd,
    output logic        frame_err,
    output logic [11:0] tune_word,
    output logic        spec_inv,
    output logic [7:0]  thr_gain,
    output logic [15:0] thr_lo,
    output logic [15:0] thr_hi,
    output logic [16:0] pkt_len_a,
    output logic [16:0] pkt_len_b,
    output logic [8:0]  sig_acc_len,
    output logic [8:0]  noise_acc_len,
    output logic [7:0]  thr_offset,
    output logic [3:0]  view_sig,
    output logic [3:0]  view_noise,
    output logic [3:0]  uw_qual,
    output logic [15:0] holdoff_sym
);
    logic       byte_vld, ferr_pulse, commit;
    logic [7:0] byte_data, commit_cnt;
    cfg_bank_t  stage, regs;
    logic [15:0] tune_raw;
    logic        unused_bits;

    scl_uart_rx #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk, .rst_n, .rxd,
        .byte_vld, .byte_data, .ferr_pulse, .frame_err
    );

    scl_assembler u_asm (
        .clk, .rst_n, .byte_vld, .byte_data, .ferr_pulse,
        .commit, .commit_cnt, .stage
    );

    scl_reg_bank u_bank (
        .clk, .rst_n, .commit, .commit_cnt, .stage, .regs
    );

    // Field decode, including the complemented encodings
    always_comb begin
        tune_raw      = {regs[P_TUNE+1], regs[P_TUNE]};
        tune_word     = tune_raw[11:0];
        spec_inv      = regs[P_SPEC][0];
        thr_gain      = regs[P_GAIN];
        thr_lo        = {regs[P_THR_LO+1], regs[P_THR_LO]};
        thr_hi        = {regs[P_THR_HI+1], regs[P_THR_HI]};
        pkt_len_a     = 17'h10000 - {1'b0, regs[P_LEN_A+1], regs[P_LEN_A]};
        pkt_len_b     = 17'h10000 - {1'b0, regs[P_LEN_B+1], regs[P_LEN_B]};
        sig_acc_len   = 9'd256 - {1'b0, regs[P_SIG_ACC]};
        noise_acc_len = 9'd256 - {1'b0, regs[P_NOI_ACC]};
        thr_offset    = regs[P_OFFSET];
        view_sig      = regs[P_VIEW][7:4];
        view_noise    = regs[P_VIEW][3:0];
        uw_qual       = regs[P_UWQ][3:0];
        holdoff_sym   = 16'hFFFF - {regs[P_HOLD+1], regs[P_HOLD]};
    end

    assign unused_bits = ^{tune_raw[15:12], regs[P_SPEC][7:1], regs[P_UWQ][7:4]};
endmodule

// File: tb/sim_ser_cfg_loader.sv
module sim_ser_cfg_loader;
    localparam int TICK_DIV = 2;
    localparam int BIT_CYC  = 16 * TICK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        frame_err, spec_inv;
    logic [11:0] tune_word;
    logic [7:0]  thr_gain, thr_offset;
    logic [15:0] thr_lo, thr_hi, holdoff_sym;
    logic [16:0] pkt_len_a, pkt_len_b;
    logic [8:0]  sig_acc_len, noise_acc_len;
    logic [3:0]  view_sig, view_noise, uw_qual;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ser_cfg_loader #(.TICK_DIV(TICK_DIV)) u0 (
        .clk, .rst_n, .rxd, .frame_err, .tune_word, .spec_inv, .thr_gain,
        .thr_lo, .thr_hi, .pkt_len_a, .pkt_len_b, .sig_acc_len, .noise_acc_len,
        .thr_offset, .view_sig, .view_noise, .uw_qual, .holdoff_sym
    );

    // Vector: bytes [95:48] (count first), expected tune [47:32], expected pkt_len_a [31:0]
    localparam logic [95:0] VEC [4] = '{
        {8'h04, 8'hF4, 8'h01, 8'h10, 8'hFF, 8'h00, 16'h01F4, 32'd240},
        {8'h02, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00, 16'h0234, 32'd240},
        {8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 32'd65536},
        {8'h04, 8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'h00, 16'h0FFF, 32'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT_CYC) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = b[k];
            repeat (BIT_CYC) @(negedge clk);
        end
        rxd = good_stop;
        repeat (BIT_CYC) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_defaults(input string req);
        check(req, 32'(tune_word), 32'h1F4);
        check(req, 32'(pkt_len_a), 32'd512);
        check(req, 32'(pkt_len_b), 32'd512);
        check(req, 32'(spec_inv), 32'd0);
        check(req, 32'(thr_gain), 32'd0);
        check(req, 32'(thr_lo), 32'h80);
        check(req, 32'(thr_hi), 32'hF0);
        check(req, 32'(sig_acc_len), 32'd192);
        check(req, 32'(noise_acc_len), 32'd192);
        check(req, 32'(thr_offset), 32'd0);
        check(req, 32'(view_sig), 32'd5);
        check(req, 32'(view_noise), 32'd1);
        check(req, 32'(uw_qual), 32'd12);
        check(req, 32'(holdoff_sym), 32'd0);
        check(req, 32'(frame_err), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] bytes;
        do_reset();
        // R7 reset state
        check_defaults("R7");

        // R1 R8 R9 vector table, each a count-prefixed string
        for (int v = 0; v < 4; v++) begin
            bytes = VEC[v][95:48];
            for (int k = 0; k <= int'(bytes[47:40]); k++)
                send_byte(bytes[47-8*k -: 8], 1'b1);
            check("R8", 32'(tune_word), 32'(VEC[v][47:32]));
            check("R9", 32'(pkt_len_a), VEC[v][31:0]);
        end
        // R5 higher positions untouched by the short strings
        check("R5", 32'(pkt_len_b), 32'd512);
        check("R5", 32'(thr_hi), 32'hF0);
        check("R5", 32'(uw_qual), 32'd12);

        // R4 zero count dropped, next byte is the count
        send_byte(8'h00, 1'b1);
        send_byte(8'h02, 1'b1); send_byte(8'h55, 1'b1); send_byte(8'h03, 1'b1);
        check("R4", 32'(tune_word), 32'h355);
        // R4 count of 20 dropped
        send_byte(8'h14, 1'b1);
        send_byte(8'h02, 1'b1); send_byte(8'h66, 1'b1); send_byte(8'h03, 1'b1);
        check("R4", 32'(tune_word), 32'h366);
        check("R4", 32'(pkt_len_a), 32'd1);

        // R6 partial string leaves outputs unchanged
        send_byte(8'h04, 1'b1); send_byte(8'h77, 1'b1); send_byte(8'h07, 1'b1);
        check("R6", 32'(tune_word), 32'h366);
        send_byte(8'h00, 1'b1);
        check("R6", 32'(tune_word), 32'h366);
        send_byte(8'hFF, 1'b1);
        check("R6", 32'(tune_word), 32'h777);
        check("R6", 32'(pkt_len_a), 32'd256);

        // R3 framing error aborts the string in progress
        send_byte(8'h04, 1'b1); send_byte(8'h11, 1'b1);
        send_byte(8'h22, 1'b0);
        check("R3", 32'(frame_err), 32'd1);
        check("R3", 32'(tune_word), 32'h777);
        send_byte(8'h02, 1'b1);
        check("R3", 32'(frame_err), 32'd0);
        send_byte(8'h88, 1'b1); send_byte(8'h01, 1'b1);
        check("R3", 32'(tune_word), 32'h188);
        check("R3", 32'(pkt_len_a), 32'd256);

        // R2 short start glitch is ignored
        @(negedge clk) rxd = 1'b0;
        repeat (TICK_DIV * 4) @(negedge clk);
        rxd = 1'b1;
        repeat (4 * BIT_CYC) @(negedge clk);
        check("R2", 32'(frame_err), 32'd0);
        send_byte(8'h02, 1'b1); send_byte(8'h45, 1'b1); send_byte(8'h02, 1'b1);
        check("R2", 32'(tune_word), 32'h245);

        // R13 full 19-byte string; R10 R11 R12 field decode
        send_byte(8'h13, 1'b1);
        send_byte(8'h11, 1'b1); send_byte(8'h02, 1'b1);
        send_byte(8'h00, 1'b1); send_byte(8'hFF, 1'b1);
        send_byte(8'h03, 1'b1); send_byte(8'h7A, 1'b1);
        send_byte(8'h34, 1'b1); send_byte(8'h12, 1'b1);
        send_byte(8'h78, 1'b1); send_byte(8'h56, 1'b1);
        send_byte(8'h00, 1'b1); send_byte(8'hFF, 1'b1);
        send_byte(8'h9C, 1'b1); send_byte(8'hA3, 1'b1);
        send_byte(8'hF0, 1'b1); send_byte(8'hFF, 1'b1);
        send_byte(8'h0E, 1'b1);
        send_byte(8'h05, 1'b1); send_byte(8'h00, 1'b1);
        check("R13", 32'(tune_word), 32'h211);
        check("R13", 32'(pkt_len_a), 32'd256);
        check("R9", 32'(pkt_len_b), 32'd16);
        check("R12", 32'(spec_inv), 32'd1);
        check("R12", 32'(thr_gain), 32'h7A);
        check("R12", 32'(thr_lo), 32'h1234);
        check("R12", 32'(thr_hi), 32'h5678);
        check("R10", 32'(sig_acc_len), 32'd256);
        check("R10", 32'(noise_acc_len), 32'd1);
        check("R12", 32'(thr_offset), 32'h9C);
        check("R12", 32'(view_sig), 32'hA);
        check("R12", 32'(view_noise), 32'h3);
        check("R12", 32'(uw_qual), 32'hE);
        check("R11", 32'(holdoff_sym), 32'hFFFA);

        // R7 reset restores every default after a full write
        do_reset();
        check_defaults("R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule